// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

The block derives raster timing from a pixel clock. A pixel counter walks each line and a line counter walks each field. From these counters it produces an undelayed horizontal sync pulse and an undelayed vertical sync pulse. It also produces a horizontal clamp window, a vertical clamp window, and an enable that marks a rectangular pixel area.

The horizontal clamp window is measured in coarse units of a prescaler that divides the pixel clock. The vertical clamp window is measured in line numbers that count from 1. The pixel area begins at the horizontal and vertical delay settings. Its width and height come from two live size inputs. A single-cycle interrupt follows each rising edge of either sync output.

Software programs the timing through an eight-entry write port. Each write is accepted in the cycle it is presented and lands in a shadow copy. The shadow copy becomes active only at the boundary between fields, so the raster in progress is never disturbed.

Top module: `video_sync_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, both counters are at zero, and the timing equals the reset parameters (line count, line length, delays, clamp limits). In that first cycle hsync, vsync, hclamp and vclamp read 1, and both interrupts read 0.
- R2: hsync is 1 during the first HS_W pixel clocks of each line. A line lasts the active line-length setting in pixel clocks.
- R3: vsync is 1 during the first VS_W lines of each field. A field lasts the active line-count setting in lines.
- R4: A write (wr_en=1) to address 0 sets line count, 1 line length, 2 vertical delay, 3 horizontal delay, 4 vertical clamp start, 5 vertical clamp stop, 6 horizontal clamp start and 7 horizontal clamp stop. The value is taken from the low bits of wr_data. A line count of 0 is stored as 1, and a line length below 2 is stored as 2. A written value governs the outputs only from the first cycle of the next field.
- R5: hclamp is 1 when floor(pixel index / PRESC), saturated at 511, is at least the horizontal clamp start and below the horizontal clamp stop. When stop ≤ start, hclamp stays 0.
- R6: vclamp is 1 when the line number (line index + 1) is at least the vertical clamp start and below the vertical clamp stop. When stop ≤ start, vclamp stays 0.
- R7: pix_en is 1 when the pixel index lies in [horizontal delay, horizontal delay + area_w) and the line index lies in [vertical delay, vertical delay + area_h).
- R8: When area_w or area_h is 0, pix_en stays 0.
- R9: irq_h is 1 for exactly the one cycle that follows a 0→1 change of hsync, and is 0 at all other times.
- R10: irq_v is 1 for exactly the one cycle that follows a 0→1 change of vsync, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, accepted every cycle |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write value, low bits used |
| area_w | input | 13 | Pixel area width in pixels |
| area_h | input | 11 | Pixel area height in lines |
| hsync | output | 1 | Undelayed horizontal sync |
| vsync | output | 1 | Undelayed vertical sync |
| hclamp | output | 1 | Horizontal clamp window |
| vclamp | output | 1 | Vertical clamp window |
| pix_en | output | 1 | Pixel area enable |
| irq_h | output | 1 | Horizontal interrupt pulse |
| irq_v | output | 1 | Vertical interrupt pulse |

## Verification
The sync, clamp and pixel-area outputs are decoded from the counter registers with no extra stage. Each is therefore due in the same cycle as the counter state it reflects, and pix_en follows a change of area_w or area_h within that cycle. The interrupts are due one clock after the corresponding sync rises. A register write first affects the outputs in the cycle after the field-end edge that follows it. The bench advances a reference raster on each rising edge, applying the shadow-to-active load before the write exactly as R4 orders them. It changes inputs just after the rising edge and compares every output at the falling edge, where these latencies are already settled.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int H_W  = 13;
  localparam int V_W  = 11;
  localparam int HC_W = 9;

  typedef struct packed {
    logic [V_W-1:0]  lines;
    logic [H_W-1:0]  hper;
    logic [V_W-1:0]  vdly;
    logic [H_W-1:0]  hdly;
    logic [V_W-1:0]  vcb;
    logic [V_W-1:0]  vce;
    logic [HC_W-1:0] hcb;
    logic [HC_W-1:0] hce;
  } cfg_t;

  typedef enum logic [2:0] {
    A_LINES = 3'd0, A_HPER = 3'd1, A_VDLY = 3'd2, A_HDLY = 3'd3,
    A_VCB   = 3'd4, A_VCE  = 3'd5, A_HCB  = 3'd6, A_HCE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
  import vsg_pkg::*;
#(
  parameter cfg_t RST_CFG = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        field_end,
  output cfg_t        act
);
  cfg_t shadow;
  logic [V_W-1:0] lines_w;
  logic [H_W-1:0] hper_w;

  // minimum legal values so the counters always wrap
  always_comb begin
    lines_w = wr_data[V_W-1:0];
    if (lines_w == '0) lines_w = V_W'(1);
    hper_w = wr_data[H_W-1:0];
    if (hper_w < H_W'(2)) hper_w = H_W'(2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_CFG;
      act    <= RST_CFG;
    end else begin
      if (field_end) act <= shadow;
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          A_LINES: shadow.lines <= lines_w;
          A_HPER:  shadow.hper  <= hper_w;
          A_VDLY:  shadow.vdly  <= wr_data[V_W-1:0];
          A_HDLY:  shadow.hdly  <= wr_data[H_W-1:0];
          A_VCB:   shadow.vcb   <= wr_data[V_W-1:0];
          A_VCE:   shadow.vce   <= wr_data[V_W-1:0];
          A_HCB:   shadow.hcb   <= wr_data[HC_W-1:0];
          default: shadow.hce   <= wr_data[HC_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/vsg_counters.sv
module vsg_counters
  import vsg_pkg::*;
#(
  parameter int PRESC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  cfg_t            act,
  output logic [H_W-1:0]  hcnt,
  output logic [V_W-1:0]  vcnt,
  output logic [HC_W-1:0] hunit,
  output logic            field_end
);
  localparam int PC_W = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic line_end;
  logic tick;

  assign line_end  = (hcnt == act.hper - H_W'(1));
  assign field_end = line_end && (vcnt == act.lines - V_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= field_end ? '0 : vcnt + V_W'(1);
    end else begin
      hcnt <= hcnt + H_W'(1);
    end
  end

  generate
    if (PRESC > 1) begin : g_div
      logic [PC_W-1:0] pc;
      assign tick = (pc == PC_W'(PRESC - 1));
      always_ff @(posedge clk) begin
        if (rst || line_end) pc <= '0;
        else if (tick)       pc <= '0;
        else                 pc <= pc + PC_W'(1);
      end
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || line_end)          hunit <= '0;
    else if (tick && hunit != '1) hunit <= hunit + HC_W'(1);
  end
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
  import vsg_pkg::*;
#(
  parameter int HS_W = 56,
  parameter int VS_W = 3
) (
  input  cfg_t            act,
  input  logic [H_W-1:0]  hcnt,
  input  logic [V_W-1:0]  vcnt,
  input  logic [HC_W-1:0] hunit,
  input  logic [H_W-1:0]  area_w,
  input  logic [V_W-1:0]  area_h,
  output logic            hs,
  output logic            vs,
  output logic            hcl,
  output logic            vcl,
  output logic            pix
);
  logic [V_W:0] line_no;
  logic         in_h, in_v;

  assign hs      = ({1'b0, hcnt} < (H_W+1)'(HS_W));
  assign vs      = ({1'b0, vcnt} < (V_W+1)'(VS_W));
  assign hcl     = (hunit >= act.hcb) && (hunit < act.hce);
  assign line_no = {1'b0, vcnt} + (V_W+1)'(1);
  assign vcl     = (line_no >= {1'b0, act.vcb}) && (line_no < {1'b0, act.vce});
  assign in_h    = (hcnt >= act.hdly) &&
                   ({1'b0, hcnt} < {1'b0, act.hdly} + {1'b0, area_w});
  assign in_v    = (vcnt >= act.vdly) &&
                   ({1'b0, vcnt} < {1'b0, act.vdly} + {1'b0, area_h});
  assign pix     = in_h && in_v;
endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
  import vsg_pkg::*;
#(
  parameter int PRESC     = 6,
  parameter int HS_W      = 56,
  parameter int VS_W      = 3,
  parameter int RST_LINES = 625,
  parameter int RST_HPER  = 768,
  parameter int RST_VDLY  = 32,
  parameter int RST_HDLY  = 72,
  parameter int RST_VCB   = 1,
  parameter int RST_VCE   = 5,
  parameter int RST_HCB   = 0,
  parameter int RST_HCE   = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [12:0] area_w,
  input  logic [10:0] area_h,
  output logic        hsync,
  output logic        vsync,
  output logic        hclamp,
  output logic        vclamp,
  output logic        pix_en,
  output logic        irq_h,
  output logic        irq_v
);
  localparam cfg_t RST_CFG = '{
    lines: V_W'(RST_LINES), hper: H_W'(RST_HPER),
    vdly:  V_W'(RST_VDLY),  hdly: H_W'(RST_HDLY),
    vcb:   V_W'(RST_VCB),   vce:  V_W'(RST_VCE),
    hcb:   HC_W'(RST_HCB),  hce:  HC_W'(RST_HCE)
  };

  cfg_t            act_cfg;
  logic [H_W-1:0]  hcnt;
  logic [V_W-1:0]  vcnt;
  logic [HC_W-1:0] hunit;
  logic            field_end;
  logic            hs_prev, vs_prev;

  vsg_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .field_end(field_end), .act(act_cfg)
  );

  vsg_counters #(.PRESC(PRESC)) u_cnt (
    .clk(clk), .rst(rst), .act(act_cfg), .hcnt(hcnt), .vcnt(vcnt),
    .hunit(hunit), .field_end(field_end)
  );

  vsg_decode #(.HS_W(HS_W), .VS_W(VS_W)) u_dec (
    .act(act_cfg), .hcnt(hcnt), .vcnt(vcnt), .hunit(hunit),
    .area_w(area_w), .area_h(area_h), .hs(hsync), .vs(vsync),
    .hcl(hclamp), .vcl(vclamp), .pix(pix_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
      irq_h   <= 1'b0;
      irq_v   <= 1'b0;
    end else begin
      hs_prev <= hsync;
      vs_prev <= vsync;
      irq_h   <= hsync & ~hs_prev;
      irq_v   <= vsync & ~vs_prev;
    end
  end
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker
  import vsg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        hsync,
  input logic        vsync,
  input logic        hclamp,
  input logic        vclamp,
  input logic        pix_en,
  input logic        irq_h,
  input logic        irq_v,
  input logic [12:0] area_w,
  input logic [10:0] area_h,
  input cfg_t        act
);
  // R9
  hirq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |=> irq_h);
  // R9
  hirq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_h |=> !irq_h);
  // R10
  virq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |=> irq_v);
  // R10
  virq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_v |=> !irq_v);
  // R5
  hclamp_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (act.hce <= act.hcb) |-> !hclamp);
  // R6
  vclamp_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (act.vce <= act.vcb) |-> !vclamp);
  // R8
  pix_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (area_w == '0 || area_h == '0) |-> !pix_en);
endmodule

bind video_sync_gen vsg_checker u_vsg_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .hclamp(hclamp),
  .vclamp(vclamp), .pix_en(pix_en), .irq_h(irq_h), .irq_v(irq_v),
  .area_w(area_w), .area_h(area_h), .act(act_cfg)
);

// File: tb/video_sync_gen_bench.sv
module video_sync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PRESC = 3, HS_W = 4, VS_W = 2;
  localparam int RL = 10, RH = 48, RVD = 3, RHD = 10;
  localparam int RVB = 1, RVE = 5, RHB = 0, RHE = 9;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [12:0] area_w = 13'd12;
  logic [10:0] area_h = 11'd4;
  logic hsync, vsync, hclamp, vclamp, pix_en, irq_h, irq_v;

  int errors = 0, checks = 0, cycles = 0;
  bit running = 1'b0;

  // reference state: index 0 lines,1 line length,2 vdly,3 hdly,4 vcb,5 vce,6 hcb,7 hce
  int sh[8], ac[8];
  int m_h, m_v;
  bit m_hsp, m_vsp, m_irqh, m_irqv;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_sync_gen #(
    .PRESC(PRESC), .HS_W(HS_W), .VS_W(VS_W), .RST_LINES(RL), .RST_HPER(RH),
    .RST_VDLY(RVD), .RST_HDLY(RHD), .RST_VCB(RVB), .RST_VCE(RVE),
    .RST_HCB(RHB), .RST_HCE(RHE)
  ) u_video_sync_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .area_w(area_w), .area_h(area_h), .hsync(hsync), .vsync(vsync),
    .hclamp(hclamp), .vclamp(vclamp), .pix_en(pix_en), .irq_h(irq_h), .irq_v(irq_v)
  );

  function automatic int stored(input int a, input int d);
    int v;
    case (a)
      0: begin v = d % 2048; if (v == 0) v = 1; end
      1: begin v = d % 8192; if (v < 2) v = 2; end
      3: v = d % 8192;
      6, 7: v = d % 512;
      default: v = d % 2048;
    endcase
    return v;
  endfunction

  function automatic bit e_hs();  return m_h < HS_W; endfunction
  function automatic bit e_vs();  return m_v < VS_W; endfunction
  function automatic bit e_hcl();
    int u = m_h / PRESC;
    if (u > 511) u = 511;
    return (u >= ac[6]) && (u < ac[7]);
  endfunction
  function automatic bit e_vcl(); return (m_v + 1 >= ac[4]) && (m_v + 1 < ac[5]); endfunction
  function automatic bit e_pix();
    return (m_h >= ac[3]) && (m_h < ac[3] + int'(area_w)) &&
           (m_v >= ac[2]) && (m_v < ac[2] + int'(area_h));
  endfunction

  task automatic chk(input string tag, input logic act_v, input bit exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cycles, act_v, exp_v);
    end
  endtask

  // reference raster, advanced on the rising edge
  always @(posedge clk) begin
    if (rst) begin
      sh = '{RL, RH, RVD, RHD, RVB, RVE, RHB, RHE};
      ac = sh;
      m_h = 0; m_v = 0;
      m_hsp = 0; m_vsp = 0; m_irqh = 0; m_irqv = 0;
    end else begin
      m_irqh = e_hs() && !m_hsp;
      m_irqv = e_vs() && !m_vsp;
      m_hsp = e_hs();
      m_vsp = e_vs();
      if (m_h == ac[1] - 1) begin
        m_h = 0;
        if (m_v == ac[0] - 1) begin
          m_v = 0;
          ac = sh;
        end else m_v++;
      end else m_h++;
      if (wr_en) sh[int'(wr_addr)] = stored(int'(wr_addr), int'(wr_data));
    end
  end

  // continuous comparison at the falling edge
  always @(negedge clk) begin
    if (running && !rst) begin
      chk("R2,R4 hsync", hsync, e_hs());
      chk("R3 vsync", vsync, e_vs());
      chk("R5 hclamp", hclamp, e_hcl());
      chk("R6 vclamp", vclamp, e_vcl());
      if (area_w == 0 || area_h == 0) chk("R8 pix_en", pix_en, 1'b0);
      else chk("R7 pix_en", pix_en, e_pix());
      chk("R9 irq_h", irq_h, m_irqh);
      chk("R10 irq_v", irq_v, m_irqv);
    end
  end

  task automatic rand_step(input int wr_pct, input bit zero_area);
    @(posedge clk); #1;
    cycles++;
    wr_en = ($urandom_range(0, 99) < wr_pct);
    if (wr_en) begin
      wr_addr = 3'($urandom_range(0, 7));
      case (wr_addr)
        3'd0: wr_data = 16'($urandom_range(0, 14));
        3'd1: wr_data = 16'($urandom_range(0, 70));
        3'd2: wr_data = 16'($urandom_range(0, 8));
        3'd3: wr_data = 16'($urandom_range(0, 30));
        3'd6, 3'd7: wr_data = 16'($urandom_range(0, 20));
        default: wr_data = 16'($urandom_range(0, 12));
      endcase
    end
    if ($urandom_range(0, 99) < 2) begin
      area_w = zero_area ? 13'd0 : 13'($urandom_range(0, 40));
      area_h = 11'($urandom_range(0, 10));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    running = 1'b1;
    @(negedge clk);
    // R1 first cycle after reset, reset timing in force
    chk("R1 hsync", hsync, 1'b1);
    chk("R1 vsync", vsync, 1'b1);
    chk("R1 hclamp", hclamp, 1'b1);
    chk("R1 vclamp", vclamp, 1'b1);
    chk("R1 irq_h", irq_h, 1'b0);
    chk("R1 irq_v", irq_v, 1'b0);
    chk("R1 pix_en", pix_en, 1'b0);
    // R1 reset field runs unchanged for a whole field
    for (int i = 0; i < RL * RH + 20; i++) rand_step(0, 1'b0);
    // R4 burst of writes, including sub-minimum values, mid field
    for (int i = 0; i < 8000; i++) rand_step(6, 1'b0);
    // R8 zero width held
    area_w = 13'd0;
    for (int i = 0; i < 3000; i++) rand_step(4, 1'b1);
    // R5 R6 empty clamp windows by construction of stop <= start
    @(posedge clk); #1 wr_en = 1; wr_addr = 3'd7; wr_data = 16'd2;
    @(posedge clk); #1 wr_addr = 3'd6; wr_data = 16'd5;
    @(posedge clk); #1 wr_addr = 3'd5; wr_data = 16'd3;
    @(posedge clk); #1 wr_addr = 3'd4; wr_data = 16'd3;
    @(posedge clk); #1 wr_en = 0; area_w = 13'd20; area_h = 11'd6;
    cycles += 5;
    for (int i = 0; i < 3000; i++) rand_step(0, 1'b0);
    for (int i = 0; i < 12000; i++) rand_step(3, 1'b0);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule